// File: doc/BRIEF.md
# Interleaved Ternary Viterbi Detector

This block takes a stream of signed three-level soft samples and recovers one data bit per sample. The sender splits its bits into two interleaved substreams, even and odd positions. Within each substream a 0 bit is sent as the level 0 and a 1 bit as a mark of level +A or −A, and the mark polarity flips after every mark. The receiver gives every other sample to one of two independent two-state maximum-likelihood detectors, so each detector runs at half the sample rate. Taken together, the two detectors form a four-state trellis. Their decisions are merged back into a single bit stream in the original order.

The decision depth is selected at run time from four values. The block delays its output by exactly twice that depth, counted in samples. When the detector is switched off, each sample is sliced against a symmetric pair of thresholds instead and produces its bit after one cycle. A change of the depth select, or of the enable, restarts both detectors. Output then stays silent until the pipeline has refilled.

Top module: `tvd_top`

## Requirements
- R1: After a synchronous reset, `bit_valid` is low until at least one sample has been accepted.
- R2: With `vit_en` low, each accepted sample produces `bit_valid` high on the following cycle, with `bit_out` = 1 exactly when |`sym_in`| > `thr` (a magnitude equal to `thr` gives 0).
- R3: In a cycle after one with `sym_valid` low, `bit_valid` is low.
- R4: `depth_sel` maps to decision depth D as 00→4, 01→6, 10→8, 11→32.
- R5: With `vit_en` high, number accepted samples i = 0, 1, 2, … from the last restart. Sample i produces no output when i < 2D. When i ≥ 2D, it produces `bit_valid` on the next cycle carrying the bit sent at position i − 2D.
- R6: Line model: samples at even i form substream 0 and samples at odd i form substream 1. In each substream, bit 0 → level 0 and bit 1 → a mark at ±`amp`. The first mark after a restart is +`amp`, and the polarity alternates after each mark.
- R7: When every sample lies within `amp`/2 (exclusive) of its ideal level, the detector output equals the sent bits, at every depth.
- R8: A restart takes place in any cycle where `vit_en` or `depth_sel` differs from its value in the previous cycle. A sample accepted in that same cycle becomes sample 0 of the new stream.
- R9: The ideal mark level follows the `amp` input, so decoding is correct for different programmed amplitudes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | Soft sample strobe |
| sym_in | input | SYM_W | Signed soft sample |
| vit_en | input | 1 | 1 = Viterbi detection, 0 = threshold slicing |
| depth_sel | input | 2 | Decision depth select |
| amp | input | AMP_W | Ideal mark amplitude |
| thr | input | AMP_W | Slicer threshold magnitude |
| bit_valid | output | 1 | Decoded bit strobe |
| bit_out | output | 1 | Decoded bit |

## Verification
The case that matters most is a configuration change and a sample acceptance falling in the same cycle. The restart must take effect, and the sample in that cycle must still be decoded as the first of the new stream. The bench provokes this in two ways. Some detector runs begin on the very cycle that `vit_en` rises. One run switches `depth_sel` from one value to another while samples keep arriving with no idle cycle. The result is judged by requiring that no output appears for the first 2D samples, and that every later output matches the bit sent 2D samples earlier in the new stream.

// File: rtl/tvd_pkg.sv
package tvd_pkg;

    localparam int SYM_W_DEF = 8;
    localparam int AMP_W_DEF = 7;
    localparam int DEPTH_MAX = 32;
    localparam int SURV_W    = DEPTH_MAX + 1;
    localparam int CNT_W     = $clog2(SURV_W + 1);

    typedef enum logic [1:0] {
        DEPTH_4  = 2'b00,
        DEPTH_6  = 2'b01,
        DEPTH_8  = 2'b10,
        DEPTH_32 = 2'b11
    } depth_code_t;

    typedef struct packed {
        logic ok;
        logic val;
    } decision_t;

    function automatic logic [CNT_W-1:0] depth_of(input depth_code_t code);
        case (code)
            DEPTH_4:  return CNT_W'(4);
            DEPTH_6:  return CNT_W'(6);
            DEPTH_8:  return CNT_W'(8);
            default:  return CNT_W'(DEPTH_MAX);
        endcase
    endfunction

endpackage

// File: rtl/tvd_slicer.sv
module tvd_slicer #(
    parameter int SYM_W = tvd_pkg::SYM_W_DEF,
    parameter int AMP_W = tvd_pkg::AMP_W_DEF
) (
    input  logic signed [SYM_W-1:0] sample,
    input  logic        [AMP_W-1:0] thr,
    output logic                    mark
);
    localparam int MAG_W = SYM_W + 1;

    logic [MAG_W-1:0] mag;

    always_comb begin
        if (sample[SYM_W-1])
            mag = MAG_W'(-$signed({sample[SYM_W-1], sample}));
        else
            mag = MAG_W'({1'b0, sample});
        mark = mag > MAG_W'(thr);
    end

endmodule

// File: rtl/tvd_lane.sv
module tvd_lane
    import tvd_pkg::*;
#(
    parameter int SYM_W = SYM_W_DEF,
    parameter int AMP_W = AMP_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    upd,
    input  logic signed [SYM_W-1:0] sample,
    input  logic        [AMP_W-1:0] amp,
    input  logic        [CNT_W-1:0] depth,
    output decision_t               dec
);
    localparam int DW   = SYM_W + 2;
    localparam int MW   = 2 * DW;
    localparam logic [MW-1:0] BIAS = MW'(1) << (MW - 3);

    // state 0: next mark is +amp, state 1: next mark is -amp
    logic [MW-1:0]     pm0_q, pm1_q;
    logic [SURV_W-1:0] sv0_q, sv1_q;
    logic [CNT_W-1:0]  cnt_q;

    logic [MW-1:0]     b_pm0, b_pm1;
    logic [SURV_W-1:0] b_sv0, b_sv1;
    logic [CNT_W-1:0]  b_cnt;

    logic [MW-1:0]     bm_zero, bm_pos, bm_neg;
    logic [MW-1:0]     s0_stay, s0_cross, s1_stay, s1_cross;
    logic [MW-1:0]     raw0, raw1, low, n_pm0, n_pm1;
    logic [SURV_W-1:0] n_sv0, n_sv1;
    logic [CNT_W-1:0]  n_cnt;
    logic              best1;

    function automatic logic [MW-1:0] sq_dist(input logic signed [SYM_W-1:0] x,
                                              input logic signed [DW-1:0] lvl);
        logic signed [DW-1:0] d;
        logic signed [MW-1:0] p;
        d = $signed({{2{x[SYM_W-1]}}, x}) - lvl;
        p = d * d;
        return MW'(p);
    endfunction

    logic signed [DW-1:0] lvl_pos, lvl_neg;

    always_comb begin
        lvl_pos = $signed({{(DW-AMP_W){1'b0}}, amp});
        lvl_neg = -lvl_pos;

        b_pm0 = clr ? '0   : pm0_q;
        b_pm1 = clr ? BIAS : pm1_q;
        b_sv0 = clr ? '0   : sv0_q;
        b_sv1 = clr ? '0   : sv1_q;
        b_cnt = clr ? '0   : cnt_q;

        bm_zero = sq_dist(sample, '0);
        bm_pos  = sq_dist(sample, lvl_pos);
        bm_neg  = sq_dist(sample, lvl_neg);

        // into state 0: stay with a space, or mark -amp from state 1
        s0_stay  = b_pm0 + bm_zero;
        s0_cross = b_pm1 + bm_neg;
        // into state 1: stay with a space, or mark +amp from state 0
        s1_stay  = b_pm1 + bm_zero;
        s1_cross = b_pm0 + bm_pos;

        if (s0_cross < s0_stay) begin
            raw0  = s0_cross;
            n_sv0 = {b_sv1[SURV_W-2:0], 1'b1};
        end else begin
            raw0  = s0_stay;
            n_sv0 = {b_sv0[SURV_W-2:0], 1'b0};
        end

        if (s1_cross < s1_stay) begin
            raw1  = s1_cross;
            n_sv1 = {b_sv0[SURV_W-2:0], 1'b1};
        end else begin
            raw1  = s1_stay;
            n_sv1 = {b_sv1[SURV_W-2:0], 1'b0};
        end

        low   = (raw1 < raw0) ? raw1 : raw0;
        n_pm0 = raw0 - low;
        n_pm1 = raw1 - low;
        best1 = raw1 < raw0;

        n_cnt = (b_cnt == CNT_W'(SURV_W)) ? b_cnt : b_cnt + 1'b1;

        dec.ok  = upd && (n_cnt > depth);
        dec.val = best1 ? n_sv1[depth] : n_sv0[depth];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pm0_q <= '0;
            pm1_q <= BIAS;
            sv0_q <= '0;
            sv1_q <= '0;
            cnt_q <= '0;
        end else if (upd) begin
            pm0_q <= n_pm0;
            pm1_q <= n_pm1;
            sv0_q <= n_sv0;
            sv1_q <= n_sv1;
            cnt_q <= n_cnt;
        end else if (clr) begin
            pm0_q <= '0;
            pm1_q <= BIAS;
            sv0_q <= '0;
            sv1_q <= '0;
            cnt_q <= '0;
        end
    end

endmodule

// File: rtl/tvd_top.sv
module tvd_top
    import tvd_pkg::*;
#(
    parameter int SYM_W = SYM_W_DEF,
    parameter int AMP_W = AMP_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sym_valid,
    input  logic signed [SYM_W-1:0] sym_in,
    input  logic                    vit_en,
    input  logic [1:0]              depth_sel,
    input  logic [AMP_W-1:0]        amp,
    input  logic [AMP_W-1:0]        thr,
    output logic                    bit_valid,
    output logic                    bit_out
);
    localparam int LANES = 2;

    logic             prev_en_q;
    logic [1:0]       prev_sel_q;
    logic             phase_q;
    logic             restart;
    logic             cur_phase;
    logic [CNT_W-1:0] depth;
    logic             slice_bit;
    decision_t        lane_dec [LANES];
    decision_t        pick;

    assign restart   = (vit_en != prev_en_q) || (depth_sel != prev_sel_q);
    assign cur_phase = restart ? 1'b0 : phase_q;
    assign depth     = depth_of(depth_code_t'(depth_sel));

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        tvd_lane #(
            .SYM_W (SYM_W),
            .AMP_W (AMP_W)
        ) u_lane (
            .clk    (clk),
            .rst    (rst),
            .clr    (restart),
            .upd    (sym_valid && vit_en && (cur_phase == k[0])),
            .sample (sym_in),
            .amp    (amp),
            .depth  (depth),
            .dec    (lane_dec[k])
        );
    end

    tvd_slicer #(
        .SYM_W (SYM_W),
        .AMP_W (AMP_W)
    ) u_slicer (
        .sample (sym_in),
        .thr    (thr),
        .mark   (slice_bit)
    );

    always_comb begin
        if (vit_en)
            pick = cur_phase ? lane_dec[1] : lane_dec[0];
        else
            pick = '{ok: sym_valid, val: slice_bit};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_en_q  <= 1'b0;
            prev_sel_q <= 2'b00;
            phase_q    <= 1'b0;
            bit_valid  <= 1'b0;
            bit_out    <= 1'b0;
        end else begin
            prev_en_q  <= vit_en;
            prev_sel_q <= depth_sel;
            phase_q    <= (sym_valid && vit_en) ? ~cur_phase : cur_phase;
            bit_valid  <= pick.ok;
            bit_out    <= pick.ok ? pick.val : 1'b0;
        end
    end

endmodule

// File: rtl/tvd_checker.sv
module tvd_checker #(
    parameter int SYM_W = tvd_pkg::SYM_W_DEF,
    parameter int AMP_W = tvd_pkg::AMP_W_DEF
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    sym_valid,
    input logic signed [SYM_W-1:0] sym_in,
    input logic                    vit_en,
    input logic [1:0]              depth_sel,
    input logic [AMP_W-1:0]        thr,
    input logic                    bit_valid,
    input logic                    bit_out
);
    logic [SYM_W:0] mag;
    assign mag = sym_in[SYM_W-1] ? (SYM_W+1)'(-$signed({sym_in[SYM_W-1], sym_in}))
                                 : {1'b0, sym_in};

    // R3
    no_spurious_out_chk: assert property (@(posedge clk) disable iff (rst)
        !sym_valid |=> !bit_valid);

    // R2
    slice_timing_chk: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && !vit_en) |=> bit_valid);

    // R2
    slice_value_chk: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && !vit_en) |=> (bit_out == ($past(mag) > (SYM_W+1)'($past(thr)))));

    // R8
    restart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && vit_en && (!$past(vit_en) || ($past(depth_sel) != depth_sel)))
        |=> !bit_valid);

endmodule

bind tvd_top tvd_checker #(.SYM_W(SYM_W), .AMP_W(AMP_W)) u_tvd_checker (
    .clk       (clk),
    .rst       (rst),
    .sym_valid (sym_valid),
    .sym_in    (sym_in),
    .vit_en    (vit_en),
    .depth_sel (depth_sel),
    .thr       (thr),
    .bit_valid (bit_valid),
    .bit_out   (bit_out)
);

// File: tb/tvd_top_tb.sv
module tvd_top_tb;
    localparam int SYM_W = 8;
    localparam int AMP_W = 7;

    logic                    clk = 1'b0;
    logic                    rst;
    logic                    sym_valid;
    logic signed [SYM_W-1:0] sym_in;
    logic                    vit_en;
    logic [1:0]              depth_sel;
    logic [AMP_W-1:0]        amp;
    logic [AMP_W-1:0]        thr;
    logic                    bit_valid;
    logic                    bit_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    bit sent [0:511];

    always #5 clk = ~clk;

    tvd_top #(.SYM_W(SYM_W), .AMP_W(AMP_W)) u_dut (
        .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_in(sym_in),
        .vit_en(vit_en), .depth_sel(depth_sel), .amp(amp), .thr(thr),
        .bit_valid(bit_valid), .bit_out(bit_out)
    );

    task automatic check(input bit cond, input string req, input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int depth_val(input logic [1:0] s);
        case (s)
            2'b00:   return 4;
            2'b01:   return 6;
            2'b10:   return 8;
            default: return 32;
        endcase
    endfunction

    function automatic bit next_bit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // Encoded sample stream; fresh=0 switches config without an idle cycle (R8)
    task automatic run_stream(input bit en, input logic [1:0] sel, input int a,
                              input bit noisy, input bit fresh, input bit gaps,
                              input int n, input string tag);
        int d;
        bit pol [2];
        d = depth_val(sel);
        pol[0] = 1'b0;
        pol[1] = 1'b0;
        if (fresh) begin
            sym_valid = 1'b0;
            vit_en    = 1'b0;
            @(negedge clk);
        end
        for (int i = 0; i < n; i++) begin
            int lvl;
            int x;
            int k;
            k = i % 2;
            sent[i] = next_bit();
            lvl = 0;
            if (sent[i]) begin
                lvl = pol[k] ? -a : a;
                pol[k] = ~pol[k];
            end
            x = lvl + (noisy ? (((i * 37) % 31) - 15) : 0);
            sym_valid = 1'b1;
            sym_in    = SYM_W'(x);
            vit_en    = en;
            depth_sel = sel;
            amp       = AMP_W'(a);
            thr       = AMP_W'(a / 2);
            @(negedge clk);
            if (!en) begin
                int mg;
                mg = (x < 0) ? -x : x;
                check(bit_valid == 1'b1, {tag, " R2 valid"}, bit_valid, 1);
                check(bit_out == (mg > a / 2), {tag, " R2 value"}, bit_out, mg > a / 2);
            end else if (i < 2 * d) begin
                check(bit_valid == 1'b0, {tag, " R5 fill"}, bit_valid, 0);
            end else begin
                check(bit_valid == 1'b1, {tag, " R5 valid"}, bit_valid, 1);
                check(bit_out == sent[i - 2 * d], {tag, " R7 value"}, bit_out, sent[i - 2 * d]);
            end
            if (gaps && (i % 5 == 4)) begin
                sym_valid = 1'b0;
                @(negedge clk);
                check(bit_valid == 1'b0, {tag, " R3 gap"}, bit_valid, 0);
            end
        end
        sym_valid = 1'b0;
    endtask

    task automatic test_reset();
        rst = 1'b1; sym_valid = 1'b0; sym_in = '0; vit_en = 1'b0;
        depth_sel = 2'b00; amp = 7'd40; thr = 7'd20;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(bit_valid == 1'b0, "R1 reset", bit_valid, 0);
    endtask

    // R2 boundary: magnitude equal to threshold slices to 0
    task automatic test_slice_edges();
        int vals [6] = '{20, -20, 21, -21, 0, -128};
        int exps [6] = '{0, 0, 1, 1, 0, 1};
        for (int i = 0; i < 6; i++) begin
            vit_en = 1'b0; thr = 7'd20; sym_valid = 1'b1; sym_in = SYM_W'(vals[i]);
            @(negedge clk);
            check(bit_valid == 1'b1 && bit_out == exps[i], "R2 edge", bit_out, exps[i]);
        end
        sym_valid = 1'b0;
        @(negedge clk);
        check(bit_valid == 1'b0, "R3 idle", bit_valid, 0);
    endtask

    initial begin
        test_reset();
        test_slice_edges();
        run_stream(1'b0, 2'b00, 40, 1'b1, 1'b1, 1'b1, 30, "slice");
        // R4 R5 R6 R7: each depth code
        run_stream(1'b1, 2'b00, 40, 1'b0, 1'b1, 1'b0, 40, "d4");
        run_stream(1'b1, 2'b01, 40, 1'b1, 1'b1, 1'b1, 50, "d6");
        run_stream(1'b1, 2'b10, 40, 1'b1, 1'b1, 1'b0, 60, "d8");
        run_stream(1'b1, 2'b11, 40, 1'b1, 1'b1, 1'b1, 130, "d32");
        // R8: depth change on a sample cycle, no idle
        run_stream(1'b1, 2'b00, 40, 1'b1, 1'b1, 1'b0, 30, "pre");
        run_stream(1'b1, 2'b01, 40, 1'b1, 1'b0, 1'b0, 40, "R8 switch");
        // R9: other amplitudes
        run_stream(1'b1, 2'b10, 100, 1'b1, 1'b1, 1'b0, 50, "R9 a100");
        run_stream(1'b1, 2'b00, 34, 1'b1, 1'b1, 1'b1, 40, "R9 a34");
        // back to slicing with no idle cycle
        run_stream(1'b0, 2'b00, 40, 1'b0, 1'b0, 1'b0, 10, "reslice");
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule